// File: doc/BRIEF.md
# Integral and Squared Integral Generator

This block consumes one grayscale frame as a raster stream of pixels, one per accepted handshake, and emits for every position two running totals. The first is the integral entry: the sum of every pixel whose row and column are both no greater than the current ones. The second is the same total taken over squared pixel values. Each entry is built from a running sum along the current row plus the entry directly above. A single line buffer per total supplies the entry above.

Both totals are sized for the worst case, a frame in which every pixel is at full scale. With the default 8-bit pixels and 320 × 240 frame, the plain total is 25 bits wide and the squared total is 33 bits wide. A separate query port takes the four corner entries of an axis-aligned rectangle and returns the rectangle's pixel sum and squared-pixel sum one cycle later. A downstream detector uses these sums for feature and variance evaluation.

Top module: `intimg_gen`

## Requirements
- R1: For a pixel at row y and column x, `out_sum` equals the sum of all pixels of the current frame at rows 0..y and columns 0..x. The arithmetic is exact in SUM_W bits (25 for the defaults).
- R2: `out_sq` equals the same region sum taken over squared pixel values, exact in SQ_W bits (33 for the defaults). It is never below `out_sum`.
- R3: A frame with every pixel at 255 yields exactly 255·COLS·ROWS (19,584,000) and 255²·COLS·ROWS (4,993,920,000) at the last position, with no wrap.
- R4: On row 0 the entry above counts as zero. On column 0 the row total starts fresh, so the origin entry is the pixel itself and its squared entry is that pixel squared.
- R5: A pixel accepted with `pix_sof`=1 is placed at row 0, column 0, even when the previous frame was incomplete.
- R6: After the pixel at column COLS−1, row ROWS−1 is accepted, the next pixel is placed at row 0, column 0 even without `pix_sof`.
- R7: `out_col` and `out_row` give the position of the entry on `out_sum`/`out_sq`. They never exceed COLS−1 and ROWS−1.
- R8: While `out_valid`=1 and `out_ready`=0, every output of the stream holds its value and `pix_ready`=0. Otherwise `pix_ready`=1.
- R9: A pixel accepted on a clock edge appears on the output stream right after that edge, with `out_valid`=1.
- R10: A query (`q_valid`=1) returns `r_sum` = D − B − C + A and `r_sq` likewise on the squared corners, with `r_valid`=1 one cycle later. D is the bottom-right entry, B the entry above the top edge, C the entry left of the left edge, and A the one diagonally above-left. Without a query, `r_valid`=0 on the following cycle.
- R11: `q_top`=1 makes the A and B corner inputs have no effect. `q_left`=1 makes the A and C corner inputs have no effect. These flags serve rectangles that touch row 0 or column 0.
- R12: During and right after reset, `out_valid`=0, `r_valid`=0 and `pix_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel taken on this edge when valid |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | PIX_W | Grayscale pixel |
| out_valid | output | 1 | Entry pair present |
| out_ready | input | 1 | Consumer takes the entry pair |
| out_sum | output | SUM_W | Integral entry |
| out_sq | output | SQ_W | Squared integral entry |
| out_col | output | COL_W | Column of the entry |
| out_row | output | ROW_W | Row of the entry |
| q_valid | input | 1 | Rectangle query strobe |
| q_top | input | 1 | Rectangle touches row 0 |
| q_left | input | 1 | Rectangle touches column 0 |
| q_a_sum | input | SUM_W | Above-left corner, plain |
| q_b_sum | input | SUM_W | Above-right corner, plain |
| q_c_sum | input | SUM_W | Below-left corner, plain |
| q_d_sum | input | SUM_W | Bottom-right corner, plain |
| q_a_sq | input | SQ_W | Above-left corner, squared |
| q_b_sq | input | SQ_W | Above-right corner, squared |
| q_c_sq | input | SQ_W | Below-left corner, squared |
| q_d_sq | input | SQ_W | Bottom-right corner, squared |
| r_valid | output | 1 | Query result present |
| r_sum | output | SUM_W | Rectangle pixel sum |
| r_sq | output | SQ_W | Rectangle squared-pixel sum |

## Verification
The hardest condition to reach is the top of the width range: the squared total only comes near bit 32 after an entire full-scale frame has been streamed. The stimulus therefore sends a complete all-255 frame first and checks both totals at the last position and through a whole-frame query. The second hard case is a frame start arriving in the middle of a frame while the output is stalled. A truncated frame with random stalls is followed directly by a new frame marker. Once a full random frame is done, more pixels are sent without a marker to reach the wrap to the origin.

// File: rtl/intimg_pkg.sv
package intimg_pkg;

    // Bits needed to hold values 0..maxval.
    function automatic int width_for(input longint unsigned maxval);
        return $clog2(maxval + 64'd1);
    endfunction

    // Largest value of an unsigned pixel of pw bits.
    function automatic longint unsigned pix_max(input int pw);
        return (64'd1 << pw) - 64'd1;
    endfunction

endpackage

// File: rtl/intimg_linebuf.sv
// One row of entries: read at the current column, written back at the same
// column on acceptance, so the read returns the value from the row above.
module intimg_linebuf #(
    parameter int DEPTH = 320,
    parameter int W     = 25,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/intimg_accum.sv
// Row running total plus the entry above gives the new integral entry.
module intimg_accum #(
    parameter int VAL_W = 8,
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first_col,
    input  logic             first_row,
    input  logic [VAL_W-1:0] val,
    input  logic [ACC_W-1:0] above,
    output logic [ACC_W-1:0] entry
);

    logic [ACC_W-1:0] run_d, run_q;
    logic [ACC_W-1:0] row_base, partial;

    always_comb begin
        row_base = first_col ? '0 : run_q;
        partial  = row_base + {{(ACC_W-VAL_W){1'b0}}, val};
        run_d    = en ? partial : run_q;
        entry    = partial + (first_row ? '0 : above);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/intimg_rect.sv
// Four-corner rectangle sum for both totals, one register stage.
module intimg_rect #(
    parameter int W0 = 25,
    parameter int W1 = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_valid,
    input  logic          q_top,
    input  logic          q_left,
    input  logic [W0-1:0] a0,
    input  logic [W0-1:0] b0,
    input  logic [W0-1:0] c0,
    input  logic [W0-1:0] d0,
    input  logic [W1-1:0] a1,
    input  logic [W1-1:0] b1,
    input  logic [W1-1:0] c1,
    input  logic [W1-1:0] d1,
    output logic          r_valid,
    output logic [W0-1:0] r0,
    output logic [W1-1:0] r1
);

    typedef struct packed {
        logic          vld;
        logic [W0-1:0] s0;
        logic [W1-1:0] s1;
    } rq_t;

    rq_t  rq_d, rq_q;
    logic keep_a, keep_b, keep_c;

    always_comb begin
        keep_b = !q_top;
        keep_c = !q_left;
        keep_a = !q_top && !q_left;
        rq_d     = rq_q;
        rq_d.vld = q_valid;
        if (q_valid) begin
            rq_d.s0 = d0 - (keep_b ? b0 : '0) - (keep_c ? c0 : '0) + (keep_a ? a0 : '0);
            rq_d.s1 = d1 - (keep_b ? b1 : '0) - (keep_c ? c1 : '0) + (keep_a ? a1 : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign r_valid = rq_q.vld;
    assign r0      = rq_q.s0;
    assign r1      = rq_q.s1;

endmodule

// File: rtl/intimg_gen.sv
module intimg_gen #(
    parameter int COLS  = 320,
    parameter int ROWS  = 240,
    parameter int PIX_W = 8,
    localparam int SUM_W = intimg_pkg::width_for(intimg_pkg::pix_max(PIX_W)
                               * longint'(COLS) * longint'(ROWS)),
    localparam int SQ_W  = intimg_pkg::width_for(intimg_pkg::pix_max(PIX_W)
                               * intimg_pkg::pix_max(PIX_W) * longint'(COLS) * longint'(ROWS)),
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic             pix_sof,
    input  logic [PIX_W-1:0] pix_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SUM_W-1:0] out_sum,
    output logic [SQ_W-1:0]  out_sq,
    output logic [COL_W-1:0] out_col,
    output logic [ROW_W-1:0] out_row,
    input  logic             q_valid,
    input  logic             q_top,
    input  logic             q_left,
    input  logic [SUM_W-1:0] q_a_sum,
    input  logic [SUM_W-1:0] q_b_sum,
    input  logic [SUM_W-1:0] q_c_sum,
    input  logic [SUM_W-1:0] q_d_sum,
    input  logic [SQ_W-1:0]  q_a_sq,
    input  logic [SQ_W-1:0]  q_b_sq,
    input  logic [SQ_W-1:0]  q_c_sq,
    input  logic [SQ_W-1:0]  q_d_sq,
    output logic             r_valid,
    output logic [SUM_W-1:0] r_sum,
    output logic [SQ_W-1:0]  r_sq
);

    localparam int SQP_W = 2 * PIX_W;

    typedef struct packed {
        logic [COL_W-1:0] col;   // position of the next pixel
        logic [ROW_W-1:0] row;
        logic             vld;
        logic [SUM_W-1:0] sum;
        logic [SQ_W-1:0]  sq;
        logic [COL_W-1:0] ocol;
        logic [ROW_W-1:0] orow;
    } st_t;

    st_t              st_d, st_q;
    logic             accept;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic             first_col, first_row;
    logic [SQP_W-1:0] pix_sq;
    logic [SUM_W-1:0] up_sum, ent_sum;
    logic [SQ_W-1:0]  up_sq, ent_sq;

    assign pix_ready = !st_q.vld || out_ready;

    // Position of the pixel on the input this cycle.
    always_comb begin
        accept    = pix_valid && pix_ready;
        cur_col   = pix_sof ? '0 : st_q.col;
        cur_row   = pix_sof ? '0 : st_q.row;
        first_col = (cur_col == '0);
        first_row = (cur_row == '0);
        pix_sq    = SQP_W'(pix_data) * SQP_W'(pix_data);
    end

    // Next state: output register and raster counters.
    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.sum  = ent_sum;
            st_d.sq   = ent_sq;
            st_d.ocol = cur_col;
            st_d.orow = cur_row;
            if (cur_col == COL_W'(COLS - 1)) begin
                st_d.col = '0;
                st_d.row = (cur_row == ROW_W'(ROWS - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                st_d.col = cur_col + 1'b1;
                st_d.row = cur_row;
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    intimg_linebuf #(.DEPTH(COLS), .W(SUM_W), .AW(COL_W)) u_lb_sum (
        .clk   (clk),
        .we    (accept),
        .addr  (cur_col),
        .wdata (ent_sum),
        .rdata (up_sum)
    );

    intimg_linebuf #(.DEPTH(COLS), .W(SQ_W), .AW(COL_W)) u_lb_sq (
        .clk   (clk),
        .we    (accept),
        .addr  (cur_col),
        .wdata (ent_sq),
        .rdata (up_sq)
    );

    intimg_accum #(.VAL_W(PIX_W), .ACC_W(SUM_W)) u_acc_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (accept),
        .first_col (first_col),
        .first_row (first_row),
        .val       (pix_data),
        .above     (up_sum),
        .entry     (ent_sum)
    );

    intimg_accum #(.VAL_W(SQP_W), .ACC_W(SQ_W)) u_acc_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (accept),
        .first_col (first_col),
        .first_row (first_row),
        .val       (pix_sq),
        .above     (up_sq),
        .entry     (ent_sq)
    );

    intimg_rect #(.W0(SUM_W), .W1(SQ_W)) u_rect (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_valid (q_valid),
        .q_top   (q_top),
        .q_left  (q_left),
        .a0      (q_a_sum),
        .b0      (q_b_sum),
        .c0      (q_c_sum),
        .d0      (q_d_sum),
        .a1      (q_a_sq),
        .b1      (q_b_sq),
        .c1      (q_c_sq),
        .d1      (q_d_sq),
        .r_valid (r_valid),
        .r0      (r_sum),
        .r1      (r_sq)
    );

    assign out_valid = st_q.vld;
    assign out_sum   = st_q.sum;
    assign out_sq    = st_q.sq;
    assign out_col   = st_q.ocol;
    assign out_row   = st_q.orow;

endmodule

// File: rtl/intimg_chk.sv
module intimg_chk #(
    parameter int COLS  = 320,
    parameter int ROWS  = 240,
    parameter int SUM_W = 25,
    parameter int SQ_W  = 33,
    parameter int COL_W = 9,
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             pix_sof,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SUM_W-1:0] out_sum,
    input logic [SQ_W-1:0]  out_sq,
    input logic [COL_W-1:0] out_col,
    input logic [ROW_W-1:0] out_row,
    input logic             q_valid,
    input logic             r_valid
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_sq)
                                    && $stable(out_col) && $stable(out_row)); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !pix_ready); // R8

    AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready |=> out_valid); // R9

    AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && pix_sof |=> out_col == '0 && out_row == '0); // R5

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_col <= COL_W'(COLS - 1) && out_row <= ROW_W'(ROWS - 1)); // R7

    AST_ORIGIN_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_col == '0 && out_row == '0
        |-> out_sq == SQ_W'(out_sum) * SQ_W'(out_sum)); // R4

    AST_SQ_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> SQ_W'(out_sum) <= out_sq); // R2

    AST_QUERY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> r_valid); // R10

    AST_QUERY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !r_valid); // R10

endmodule

bind intimg_gen intimg_chk #(
    .COLS(COLS), .ROWS(ROWS), .SUM_W(SUM_W), .SQ_W(SQ_W), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_sof   (pix_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sum   (out_sum),
    .out_sq    (out_sq),
    .out_col   (out_col),
    .out_row   (out_row),
    .q_valid   (q_valid),
    .r_valid   (r_valid)
);

// File: tb/sim_intimg_gen.sv
module sim_intimg_gen;

    localparam int COLS = 320;
    localparam int ROWS = 240;
    localparam int PW   = 8;
    localparam int SW   = 25;
    localparam int QW   = 33;
    localparam int CW   = $clog2(COLS);
    localparam int RW   = $clog2(ROWS);
    localparam int NPIX = COLS * ROWS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0, pix_sof = 1'b0, out_ready = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic          pix_ready, out_valid, r_valid;
    logic [SW-1:0] out_sum, r_sum;
    logic [QW-1:0] out_sq, r_sq;
    logic [CW-1:0] out_col;
    logic [RW-1:0] out_row;
    logic          q_valid = 1'b0, q_top = 1'b0, q_left = 1'b0;
    logic [SW-1:0] q_a_sum = '0, q_b_sum = '0, q_c_sum = '0, q_d_sum = '0;
    logic [QW-1:0] q_a_sq = '0, q_b_sq = '0, q_c_sq = '0, q_d_sq = '0;

    intimg_gen #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_sof(pix_sof), .pix_data(pix_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sum(out_sum), .out_sq(out_sq), .out_col(out_col), .out_row(out_row),
        .q_valid(q_valid), .q_top(q_top), .q_left(q_left),
        .q_a_sum(q_a_sum), .q_b_sum(q_b_sum), .q_c_sum(q_c_sum), .q_d_sum(q_d_sum),
        .q_a_sq(q_a_sq), .q_b_sq(q_b_sq), .q_c_sq(q_c_sq), .q_d_sq(q_d_sq),
        .r_valid(r_valid), .r_sum(r_sum), .r_sq(r_sq)
    );

    always #2 clk = ~clk;   // 250 MHz

    int vectors = 0;
    int misses  = 0;

    task automatic chk(input string req, input string what,
                       input longint unsigned got, input longint unsigned exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Reference model state
    int                mcol = 0, mrow = 0;
    longint unsigned   rs_i = 0, rs_q = 0;
    int                pix_mem [NPIX];
    longint unsigned   ii [NPIX];
    longint unsigned   iq [NPIX];
    bit                mid_frame = 0, wrapped = 0, white = 0;
    longint unsigned   eq_s [$];
    longint unsigned   eq_q [$];
    int                eq_c [$];
    int                eq_r [$];
    string             eq_t [$];

    task automatic model_push(input int p, input bit sof);
        longint unsigned e_i, e_q;
        int idx;
        string tag;
        if (sof) tag = mid_frame ? "R5" : "R1";
        else if (wrapped && mcol == 0 && mrow == 0) tag = "R6";
        else tag = "R1";
        if (tag == "R1" && (mcol == 0 || mrow == 0)) tag = "R4";
        wrapped = 0;
        if (sof) begin mcol = 0; mrow = 0; end
        if (mcol == 0) begin rs_i = 0; rs_q = 0; end
        rs_i += longint'(p);
        rs_q += longint'(p * p);
        idx = mrow * COLS + mcol;
        e_i = rs_i + ((mrow > 0) ? ii[idx - COLS] : 0);
        e_q = rs_q + ((mrow > 0) ? iq[idx - COLS] : 0);
        pix_mem[idx] = p;
        ii[idx] = e_i;
        iq[idx] = e_q;
        eq_s.push_back(e_i); eq_q.push_back(e_q);
        eq_c.push_back(mcol); eq_r.push_back(mrow); eq_t.push_back(tag);
        mid_frame = 1;
        if (mcol == COLS - 1) begin
            mcol = 0;
            if (mrow == ROWS - 1) begin mrow = 0; wrapped = 1; mid_frame = 0; end
            else mrow++;
        end else mcol++;
    endtask

    task automatic pop_check();
        longint unsigned es, eqv;
        int ec, er;
        string t;
        if (eq_s.size() == 0) begin
            chk("R9", "unexpected output", 1, 0);
            return;
        end
        es = eq_s.pop_front(); eqv = eq_q.pop_front();
        ec = eq_c.pop_front(); er = eq_r.pop_front(); t = eq_t.pop_front();
        chk(t, "sum", out_sum, es);
        chk("R2", "sq", out_sq, eqv);
        chk("R7", "col", out_col, longint'(ec));
        chk("R7", "row", out_row, longint'(er));
        if (white && ec == COLS - 1 && er == ROWS - 1) begin
            chk("R3", "max sum", out_sum, 64'd255 * NPIX);
            chk("R3", "max sq", out_sq, 64'd65025 * NPIX);
        end
    endtask

    bit              last_acc = 0, stall_prev = 0;
    longint unsigned held_sum = 0, held_sq = 0;

    task automatic step(input bit v, input bit sof, input int p, input bit ordy, output bit acc);
        @(negedge clk);
        pix_valid = v; pix_sof = sof; pix_data = p[PW-1:0]; out_ready = ordy;
        #1;
        if (last_acc) chk("R9", "out_valid after accept", out_valid, 1);
        if (stall_prev) begin
            chk("R8", "valid held", out_valid, 1);
            chk("R8", "sum held", out_sum, held_sum);
            chk("R8", "sq held", out_sq, held_sq);
        end
        if (out_valid && !out_ready) begin
            chk("R8", "pix_ready in stall", pix_ready, 0);
            stall_prev = 1; held_sum = out_sum; held_sq = out_sq;
        end else begin
            stall_prev = 0;
        end
        if (out_valid && out_ready) pop_check();
        acc = v && pix_ready;
        if (acc) model_push(p, sof);
        last_acc = acc;
    endtask

    task automatic send(input int p, input bit sof, input bit jitter);
        bit a;
        do begin
            bit v = !(jitter && ($urandom % 5 == 0));
            bit r = !(jitter && ($urandom % 4 == 0));
            step(v, sof, p, r, a);
        end while (!a);
    endtask

    task automatic drain();
        bit a;
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, a);
        chk("R9", "all outputs delivered", eq_s.size(), 0);
    endtask

    task automatic query(input int x0, input int y0, input int x1, input int y1);
        longint unsigned xs = 0, xq = 0;
        string t;
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) begin
                xs += longint'(pix_mem[y * COLS + x]);
                xq += longint'(pix_mem[y * COLS + x] * pix_mem[y * COLS + x]);
            end
        t = (x0 == 0 || y0 == 0) ? "R11" : "R10";
        @(negedge clk);
        q_valid = 1; q_top = (y0 == 0); q_left = (x0 == 0);
        q_d_sum = SW'(ii[y1 * COLS + x1]); q_d_sq = QW'(iq[y1 * COLS + x1]);
        // ignored corners carry junk
        q_a_sum = SW'($urandom); q_a_sq = QW'({$urandom, $urandom});
        q_b_sum = SW'($urandom); q_b_sq = QW'({$urandom, $urandom});
        q_c_sum = SW'($urandom); q_c_sq = QW'({$urandom, $urandom});
        if (y0 > 0) begin
            q_b_sum = SW'(ii[(y0 - 1) * COLS + x1]); q_b_sq = QW'(iq[(y0 - 1) * COLS + x1]);
        end
        if (x0 > 0) begin
            q_c_sum = SW'(ii[y1 * COLS + x0 - 1]); q_c_sq = QW'(iq[y1 * COLS + x0 - 1]);
        end
        if (x0 > 0 && y0 > 0) begin
            q_a_sum = SW'(ii[(y0 - 1) * COLS + x0 - 1]); q_a_sq = QW'(iq[(y0 - 1) * COLS + x0 - 1]);
        end
        @(negedge clk);
        q_valid = 0;
        chk("R10", "r_valid", r_valid, 1);
        chk(t, "rect sum", r_sum, xs);
        chk(t, "rect sq", r_sq, xq);
        @(negedge clk);
        chk("R10", "r_valid idle", r_valid, 0);
    endtask

    initial begin : watchdog
        repeat (199000) @(posedge clk);
        misses++; vectors++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "out_valid in reset", out_valid, 0);
        chk("R12", "r_valid in reset", r_valid, 0);
        chk("R12", "pix_ready in reset", pix_ready, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R12", "out_valid after reset", out_valid, 0);

        // Full-scale frame: R3
        white = 1;
        for (int i = 0; i < NPIX; i++) send(255, i == 0, 0);
        drain();
        white = 0;
        query(0, 0, COLS - 1, ROWS - 1);
        chk("R3", "whole-frame query sum", r_sum, 64'd255 * NPIX);
        chk("R3", "whole-frame query sq", r_sq, 64'd65025 * NPIX);

        // Truncated frame with stalls, then a new marker mid-frame: R5
        for (int i = 0; i < 700; i++) send($urandom % 256, i == 0, 1);
        for (int i = 0; i < NPIX; i++) send($urandom % 256, i == 0, i < 3000);
        drain();

        // Rectangle queries on the random frame: R10, R11
        query(0, 0, 0, 0);
        query(0, 5, 10, 20);
        query(7, 0, 30, 3);
        query(1, 1, 1, 1);
        query(COLS - 20, ROWS - 20, COLS - 1, ROWS - 1);
        for (int k = 0; k < 20; k++) begin
            int x0 = $urandom % COLS;
            int y0 = $urandom % ROWS;
            int x1 = x0 + ($urandom % 40);
            int y1 = y0 + ($urandom % 40);
            if (x1 > COLS - 1) x1 = COLS - 1;
            if (y1 > ROWS - 1) y1 = ROWS - 1;
            query(x0, y0, x1, y1);
        end

        // Pixels after a complete frame without a marker: R6
        for (int i = 0; i < 50; i++) send($urandom % 256, 0, 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule